// File: doc/BRIEF.md
# I2C Register Access Port

This block is an I2C slave that gives an external bus master write and read access to a window of 8-bit control registers at indices 0x40 to 0x5E (31 registers). Both bus lines are brought into the system clock domain through two-flop synchronizers. The block finds start, repeated start and stop conditions from the synchronized lines. It answers only to one fixed 7-bit device address.

A write transaction carries a register index byte followed by any number of data bytes. A read begins with a write transaction that sets the index only. The master then issues a repeated start and sends the device address with the read bit. The slave returns bytes from the stored index for as long as the master acknowledges them.

The index steps forward after every byte and stays inside the window. All register contents are presented on one flat parallel bus for use by the rest of the chip. The slave only ever pulls SDA low, through an output enable, and the bus provides the pull-up.

Top module: `i2c_regport`

## Requirements
- R1: After reset every register reads 0x00 and the SDA output enable is low, which means SDA is released.
- R2: The first byte after a start is the device address in its upper 7 bits, with the direction in bit 0 (1 = read, 0 = write). When the upper 7 bits equal DEV_ADDR (default 0x4C), the slave acknowledges by holding SDA low during the ninth clock. Otherwise it does not acknowledge and does not drive SDA until the next start.
- R3: In a write transaction, an index byte in the range 0x40 to 0x5E is acknowledged and stored. An index byte outside that range is not acknowledged, leaves the stored index unchanged, and causes the data bytes that follow to be neither acknowledged nor written.
- R4: Data bytes are received MSB first, acknowledged, and written to the register at the current index. The register at index 0x40+k appears on regs_o bits [8k+7:8k], and no other register changes.
- R5: The index advances by one after every data byte written and after every data byte sent. The index after 0x5E is 0x40.
- R6: After the device address with the read bit is acknowledged, the slave sends the register at the current index MSB first. It keeps sending further bytes while the master acknowledges, and releases SDA once the master answers with a NACK.
- R7: A stop or a start in the middle of a byte abandons that byte without writing it and returns the slave to the address phase or to idle. The stored index is kept, so a later read that sends no index returns the register at that kept index.
- R8: The SDA output enable changes only while SCL is low. It is high only while the slave is sending an acknowledge or a read-data 0 bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low; when low, SDA is released |
| regs_o | output | 248 | All 31 registers; index 0x40+k at bits [8k+7:8k] |

## Verification
A wrong index shows up at the ports within one byte: the next write changes the wrong slice of regs_o, or the next read returns a value the bench did not expect. A wrong link state shows up in the ninth clock of the affected byte, as an acknowledge where a NACK was due or the reverse. A slip in the bit counter corrupts the byte being returned or written right away. The sweeps walk every index in the window, wrap the index in both directions of transfer, try every foreign device address, and hit the index bounds on both sides, so a fault in any of these paths appears within a few bytes.

// File: rtl/i2c_regport_pkg.sv
// Package: shared types for the I2C register access port.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_regport_pkg;

    // Phases of the bus link as seen by the slave.
    typedef enum logic [3:0] {
        LS_IDLE,
        LS_ADDR,
        LS_ADDR_ACK,
        LS_INDEX,
        LS_INDEX_ACK,
        LS_WDATA,
        LS_WDATA_ACK,
        LS_RDATA,
        LS_RACK,
        LS_IGNORE
    } link_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the system clock domain and reports clock edges
// and start/stop conditions as single-cycle strobes.
// Assumes: the system clock is many times faster than SCL, so every bus
// level lasts several system clocks. Both lines reset to the idle level (1).
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    // One stage beyond the synchronizer holds the previous level for edges.
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Shift both bus lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    // Decode levels, edges and bus conditions from the synchronized lines.
    always_comb begin
        scl_s     = scl_pipe[SYNC_STAGES-1];
        sda_s     = sda_pipe[SYNC_STAGES-1];
        scl_prev  = scl_pipe[SYNC_STAGES];
        sda_prev  = sda_pipe[SYNC_STAGES];
        scl_rise  = scl_s && !scl_prev;
        scl_fall  = !scl_s && scl_prev;
        start_det = scl_s && scl_prev && sda_prev && !sda_s;
        stop_det  = scl_s && scl_prev && !sda_prev && sda_s;
    end

endmodule

// File: rtl/i2c_index_ctr.sv
// Module: i2c_index_ctr
// Holds the register index, loads it from an accepted index byte, steps it
// by one and wraps from the last index back to the first. Also judges
// whether a candidate index byte lies inside the window.
// Assumes: load and step are never requested in the same cycle; load is
// only requested for a candidate judged in range.
module i2c_index_ctr #(
    parameter int             IDX_W    = 8,
    parameter logic [IDX_W-1:0] REG_BASE = 8'h40,
    parameter logic [IDX_W-1:0] REG_LAST = 8'h5E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cand_i,
    output logic             cand_ok_o,
    input  logic             load_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [IDX_W-1:0] idx_q;

    // Range check on the byte just received in the index phase.
    always_comb begin
        cand_ok_o = (cand_i >= REG_BASE) && (cand_i <= REG_LAST);
        idx_o     = idx_q;
    end

    // Index register: load, step with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= REG_BASE;
        end else if (load_i) begin
            idx_q <= cand_i;
        end else if (step_i) begin
            idx_q <= (idx_q == REG_LAST) ? REG_BASE : idx_q + 1'b1;
        end
    end

    assert_idx_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q >= REG_BASE) && (idx_q <= REG_LAST));

    assert_idx_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && idx_q == REG_LAST) |=> (idx_q == REG_BASE));

    assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && idx_q != REG_LAST) |=> (idx_q == $past(idx_q) + 1'b1));

    assert_load_valid_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> cand_ok_o);

endmodule

// File: rtl/i2c_reg_bank.sv
// Module: i2c_reg_bank
// The register window: one write port addressed by index, one read port
// addressed by index, and all contents flattened onto a parallel bus.
// Assumes: write and read indices lie within the window.
module i2c_reg_bank #(
    parameter int               IDX_W    = 8,
    parameter int               DATA_W   = 8,
    parameter int               NUM_REGS = 31,
    parameter logic [IDX_W-1:0] REG_BASE = 8'h40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [IDX_W-1:0]           wr_idx_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic [IDX_W-1:0]           rd_idx_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // One storage register, written when the index selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == REG_BASE + IDX_W'(g))) begin
                regs_q[g] <= wr_data_i;
            end
        end
        assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];
    end

    // Read multiplexer selecting the register at the read index.
    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx_i == REG_BASE + IDX_W'(k)) begin
                rd_data_o = regs_q[k];
            end
        end
    end

    assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/i2c_link_ctrl.sv
// Module: i2c_link_ctrl
// Bit and byte sequencer of the slave: shifts in address, index and write
// bytes on SCL rising, drives acknowledges and read bits on SCL falling,
// and issues index load/step and register write strobes.
// Assumes: edge and condition strobes come from i2c_line_sync; start and
// stop never coincide with an SCL edge.
module i2c_link_ctrl
    import i2c_regport_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h4C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              cand_ok_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              idx_load_o,
    output logic              idx_step_o,
    output logic              wr_en_o,
    output logic              sda_oe_o
);

    localparam int          CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);

    link_state_t        state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DATA_W-1:0]  sh_q;
    logic               oe_q;
    logic               rw_q;
    logic               mack_q;
    logic               abort;
    logic               byte_done;
    logic               receiving;

    // Strobes for the index counter and the register bank.
    always_comb begin
        abort      = start_det || stop_det;
        byte_done  = scl_fall && (cnt_q == BYTE_END);
        receiving  = (state_q == LS_ADDR) || (state_q == LS_INDEX) || (state_q == LS_WDATA);
        idx_load_o = !abort && (state_q == LS_INDEX) && byte_done && cand_ok_i;
        wr_en_o    = !abort && (state_q == LS_WDATA) && byte_done;
        idx_step_o = wr_en_o || (!abort && (state_q == LS_RACK) && scl_rise);
        byte_o     = sh_q;
        sda_oe_o   = oe_q;
    end

    // Link state machine with shift register, bit counter and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            oe_q    <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else if (stop_det) begin
            state_q <= LS_IDLE;
            oe_q    <= 1'b0;
        end else if (start_det) begin
            state_q <= LS_ADDR;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
        end else if (receiving) begin
            if (scl_rise && cnt_q != BYTE_END) begin
                sh_q  <= {sh_q[DATA_W-2:0], sda_s};
                cnt_q <= cnt_q + 1'b1;
            end
            if (byte_done) begin
                cnt_q <= '0;
                unique case (state_q)
                    LS_ADDR: begin
                        if (sh_q[DATA_W-1:1] == DEV_ADDR) begin
                            oe_q    <= 1'b1;
                            rw_q    <= sh_q[0];
                            state_q <= LS_ADDR_ACK;
                        end else begin
                            state_q <= LS_IGNORE;
                        end
                    end
                    LS_INDEX: begin
                        if (cand_ok_i) begin
                            oe_q    <= 1'b1;
                            state_q <= LS_INDEX_ACK;
                        end else begin
                            state_q <= LS_IGNORE;
                        end
                    end
                    default: begin
                        oe_q    <= 1'b1;
                        state_q <= LS_WDATA_ACK;
                    end
                endcase
            end
        end else begin
            unique case (state_q)
                LS_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            sh_q    <= rd_data_i;
                            oe_q    <= !rd_data_i[DATA_W-1];
                            state_q <= LS_RDATA;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= LS_INDEX;
                        end
                    end
                end
                LS_INDEX_ACK, LS_WDATA_ACK: begin
                    if (scl_fall) begin
                        oe_q    <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= LS_WDATA;
                    end
                end
                LS_RDATA: begin
                    if (scl_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (scl_fall) begin
                        if (cnt_q == BYTE_END) begin
                            oe_q    <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= LS_RACK;
                        end else begin
                            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
                            oe_q <= !sh_q[DATA_W-2];
                        end
                    end
                end
                LS_RACK: begin
                    if (scl_rise) begin
                        mack_q <= !sda_s;
                    end
                    if (scl_fall) begin
                        if (mack_q) begin
                            sh_q    <= rd_data_i;
                            oe_q    <= !rd_data_i[DATA_W-1];
                            state_q <= LS_RDATA;
                        end else begin
                            state_q <= LS_IGNORE;
                        end
                    end
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assert_oe_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q != $past(oe_q)) |-> !scl_s);

    assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == LS_IDLE && !oe_q));

    assert_ignore_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_IGNORE) |-> !oe_q);

    assert_master_ack_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_RACK) |-> !oe_q);

    assert_start_to_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state_q == LS_ADDR && cnt_q == '0));

endmodule

// File: rtl/i2c_regport.sv
// Module: i2c_regport (top)
// I2C slave giving bus access to a window of control registers and
// presenting their contents as a parallel bus.
// Assumes: open-drain pad outside; sda_oe_o high pulls SDA low.
module i2c_regport #(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter logic [7:0] REG_BASE = 8'h40,
    parameter logic [7:0] REG_LAST = 8'h5E,
    parameter int         SYNC_STAGES = 2,
    localparam int        NUM_REGS = int'(REG_LAST) - int'(REG_BASE) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    localparam int IDX_W  = 8;
    localparam int DATA_W = 8;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              cand_ok, idx_load, idx_step, wr_en;
    logic [DATA_W-1:0] byte_val, rd_data;
    logic [IDX_W-1:0]  idx;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_link_ctrl #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) link_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .cand_ok_i(cand_ok), .rd_data_i(rd_data), .byte_o(byte_val),
        .idx_load_o(idx_load), .idx_step_o(idx_step), .wr_en_o(wr_en),
        .sda_oe_o(sda_oe_o)
    );

    i2c_index_ctr #(.IDX_W(IDX_W), .REG_BASE(REG_BASE), .REG_LAST(REG_LAST)) index_i (
        .clk(clk), .rst_n(rst_n), .cand_i(byte_val), .cand_ok_o(cand_ok),
        .load_i(idx_load), .step_i(idx_step), .idx_o(idx)
    );

    i2c_reg_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
                   .REG_BASE(REG_BASE)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(idx),
        .wr_data_i(byte_val), .rd_idx_i(idx), .rd_data_o(rd_data),
        .regs_o(regs_o)
    );

    assert_write_not_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && idx_load));

endmodule

// File: tb/i2c_regport_tb_top.sv
// Bench: drives the bus as a master, keeps a register model, and checks
// acknowledges, read data and the parallel register bus.
module i2c_regport_tb_top;

    localparam int         Q    = 8;
    localparam int         NREG = 31;
    localparam logic [6:0] DEV  = 7'h4C;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_line = sda_m & ~sda_oe;

    i2c_regport dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    int checks = 0;
    int errors = 0;
    int r8_viol = 0;
    logic oe_prev = 1'b0;
    logic [7:0] mdl [NREG];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R8 monitor: output enable may only move while the master holds SCL low.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) r8_viol++;
        oe_prev = sda_oe;
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); b = sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic write_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = !a;
    endtask

    task automatic read_byte(input logic master_nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(master_nack);
    endtask

    task automatic cmp_regs(input string req);
        for (int k = 0; k < NREG; k++)
            chk(regs[8*k +: 8] == mdl[k], req, $sformatf("regs_o slot %0d", k),
                32'(regs[8*k +: 8]), 32'(mdl[k]));
    endtask

    // Read one byte without sending an index; returns it.
    task automatic read_current(output logic [7:0] v);
        logic a;
        bus_start();
        write_byte({DEV, 1'b1}, a);
        chk(a, "R6", "ack of read address", 32'(a), 32'd1);
        read_byte(1'b1, v);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] v;
        int idx;
        logic [7:0] bad_idx [10] = '{8'h00, 8'h20, 8'h3E, 8'h3F, 8'h5F,
                                     8'h60, 8'h7F, 8'h80, 8'hC0, 8'hFF};

        for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
        repeat (10) @(negedge clk);
        // R1: reset state.
        chk(sda_oe == 1'b0, "R1", "sda_oe in reset", 32'(sda_oe), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R1", "sda_oe after reset", 32'(sda_oe), 32'd0);
        cmp_regs("R1");

        // R2, R3, R4: burst write of the whole window from 0x40.
        bus_start();
        write_byte({DEV, 1'b0}, a);
        chk(a, "R2", "ack of own write address", 32'(a), 32'd1);
        write_byte(8'h40, a);
        chk(a, "R3", "ack of index 0x40", 32'(a), 32'd1);
        for (int k = 0; k < NREG; k++) begin
            v = 8'((k * 37 + 5) & 8'hFF);
            write_byte(v, a);
            chk(a, "R4", $sformatf("ack of data byte %0d", k), 32'(a), 32'd1);
            mdl[k] = v;
        end
        bus_stop();
        cmp_regs("R4");

        // R5: write burst crossing the wrap from 0x5E to 0x40.
        bus_start();
        write_byte({DEV, 1'b0}, a);
        write_byte(8'h5C, a);
        chk(a, "R3", "ack of index 0x5C", 32'(a), 32'd1);
        idx = 8'h5C - 8'h40;
        for (int i = 0; i < 5; i++) begin
            v = 8'hA0 + 8'(i);
            write_byte(v, a);
            chk(a, "R5", "ack of wrapping write", 32'(a), 32'd1);
            mdl[idx] = v;
            idx = (idx + 1) % NREG;
        end
        bus_stop();
        cmp_regs("R5");

        // R6, R5: indexed read burst with repeated start, wrapping once.
        bus_start();
        write_byte({DEV, 1'b0}, a);
        write_byte(8'h50, a);
        chk(a, "R3", "ack of index 0x50", 32'(a), 32'd1);
        bus_start();
        write_byte({DEV, 1'b1}, a);
        chk(a, "R2", "ack of own read address", 32'(a), 32'd1);
        idx = 8'h50 - 8'h40;
        for (int i = 0; i < 34; i++) begin
            read_byte(i == 33, v);
            chk(v == mdl[idx], "R6", $sformatf("read byte %0d", i), 32'(v), 32'(mdl[idx]));
            idx = (idx + 1) % NREG;
        end
        qwait();
        chk(sda_oe == 1'b0, "R6", "released after master NACK", 32'(sda_oe), 32'd0);
        bus_stop();

        // R7, R5: index kept across transactions for a read with no index.
        read_current(v);
        chk(v == mdl[idx], "R7", "read at kept index", 32'(v), 32'(mdl[idx]));
        idx = (idx + 1) % NREG;

        // R3: indices outside the window are refused and change nothing.
        for (int b = 0; b < 10; b++) begin
            bus_start();
            write_byte({DEV, 1'b0}, a);
            write_byte(bad_idx[b], a);
            chk(!a, "R3", $sformatf("NACK of index %0h", bad_idx[b]), 32'(a), 32'd0);
            write_byte(8'h99, a);
            chk(!a, "R3", "NACK of data after bad index", 32'(a), 32'd0);
            bus_stop();
        end
        cmp_regs("R3");
        read_current(v);
        chk(v == mdl[idx], "R3", "index unchanged by bad index", 32'(v), 32'(mdl[idx]));
        idx = (idx + 1) % NREG;

        // R2: every foreign device address is refused.
        for (int d = 0; d < 128; d++) begin
            if (7'(d) != DEV) begin
                bus_start();
                write_byte({7'(d), 1'b0}, a);
                chk(!a, "R2", $sformatf("NACK of address %0h", d), 32'(a), 32'd0);
                bus_stop();
            end
        end
        bus_start();
        write_byte({7'h4D, 1'b1}, a);
        chk(!a, "R2", "NACK of foreign read address", 32'(a), 32'd0);
        write_byte(8'h00, a);
        chk(!a, "R2", "silent after foreign address", 32'(a), 32'd0);
        bus_stop();
        cmp_regs("R2");

        // R7: stop in the middle of a data byte discards it.
        bus_start();
        write_byte({DEV, 1'b0}, a);
        write_byte(8'h45, a);
        write_byte(8'h11, a);
        chk(a, "R4", "ack of data at 0x45", 32'(a), 32'd1);
        mdl[5] = 8'h11;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        cmp_regs("R7");

        // R7: start in the middle of a byte restarts at the address phase.
        bus_start();
        write_byte({DEV, 1'b0}, a);
        write_byte(8'h48, a);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        write_byte({DEV, 1'b1}, a);
        chk(a, "R7", "ack of address after mid-byte start", 32'(a), 32'd1);
        read_byte(1'b1, v);
        chk(v == mdl[8], "R7", "read after mid-byte start", 32'(v), 32'(mdl[8]));
        bus_stop();
        read_current(v);
        chk(v == mdl[9], "R5", "index advanced past read", 32'(v), 32'(mdl[9]));
        cmp_regs("R7");

        // R8: output enable never moved while SCL was high.
        chk(r8_viol == 0, "R8", "oe changes while SCL high", 32'(r8_viol), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule